// File: doc/BRIEF.md
# Atomic Double-Width Compare-and-Swap Unit

This unit carries out one compare-and-exchange on a memory location. The location is either 64 or 128 bits wide. A request brings an address, a width select, an expected value and a replacement value. Each value arrives as a high half and a low half. The unit first checks the request for faults. If it finds none, it locks the memory port and reads the location. It then compares what it read with the expected value and writes a result back under the same lock. On a match it writes the replacement. On a mismatch it writes back the value it just read, so every locked read has a matching write.

The caller gets back four things: the value that was in memory, a success flag, a fault code and a sticky equality flag. The other five condition flags pass straight from input to output. The caller updates its expected-value register pair from the returned old value when the compare fails. The memory side is a single-beat port with a valid/ready handshake, a write select, a width select and a lock line.

The state sequence is IDLE → CHECK → LOCK_READ → COMPARE → LOCK_WRITE → DONE → IDLE. A fault found in CHECK goes straight to DONE. The named transitions are:
- accept (IDLE→CHECK on request valid)
- fault exit (CHECK→DONE)
- check pass (CHECK→LOCK_READ)
- read ack (LOCK_READ→COMPARE on ready)
- decide (COMPARE→LOCK_WRITE)
- write ack (LOCK_WRITE→DONE on ready)
- retire (DONE→IDLE)

Top module: `cas_unit`

## Requirements
- R1: Width select 1 means 128-bit: both values are {hi[63:0], lo[63:0]}, with hi as the upper half. Width select 0 means 64-bit: only hi[31:0] and lo[31:0] take part, and the upper 32 bits of each input half are ignored. Memory data for a 64-bit access sits in bits [63:0], and the upper 64 bits of write data are zero.
- R2: When the loaded value equals the expected value, the unit writes the replacement to the same address, sets `success`, and reports fault 0.
- R3: On a mismatch, the unit clears `success`, writes the loaded value back unchanged, and returns it on `old_hi`/`old_lo`. In 64-bit mode these are zero-extended 32-bit halves.
- R4: A fault-free operation makes exactly one locked read and then exactly one locked write to the same address. `mem_lock` rises with the read, stays high through COMPARE, and falls only after the write is acknowledged.
- R5: A 128-bit request with address[3:0] not zero gives fault code 3 and makes no memory access.
- R6: A 128-bit request while `wide_enable` is low gives fault code 2 and makes no memory access.
- R7: A 64-bit request with address[2:0] not zero, while `align_chk_en` is 1 and `priv_level` is 3, gives fault code 4 and makes no memory access. With either condition absent, the access goes ahead.
- R8: A request with `req_not_mem` set gives fault code 1 and makes no memory access.
- R9: When several fault conditions hold, the lowest code is reported, in the order 1, 2, 3, 4.
- R10: `flags_out` always equals `flags_in`. `eq_flag` takes the value of `success` after each fault-free operation and keeps its old value across a faulting one.
- R11: `done` is high for exactly one cycle per accepted request. While the memory port is not ready, the unit holds its request, address and write select.
- R12: After reset, `req_ready` is 1, and `done`, `mem_req_valid`, `mem_lock`, `eq_flag`, `success` and `fault` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle; the request is accepted on this cycle |
| req_addr | input | ADDR_W | Byte address of the destination |
| req_wide | input | 1 | 1 = 128-bit operation, 0 = 64-bit |
| req_not_mem | input | 1 | Destination is not a memory operand |
| req_cmp_hi | input | HALF_W | Expected value, high half |
| req_cmp_lo | input | HALF_W | Expected value, low half |
| req_new_hi | input | HALF_W | Replacement value, high half |
| req_new_lo | input | HALF_W | Replacement value, low half |
| wide_enable | input | 1 | 128-bit operation permitted |
| align_chk_en | input | 1 | Alignment checking enabled |
| priv_level | input | 2 | Current privilege level |
| flags_in | input | 5 | Carry, parity, adjust, sign, overflow in |
| flags_out | output | 5 | The same five flags, unchanged |
| eq_flag | output | 1 | Equality flag |
| mem_req_valid | output | 1 | Memory access request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_lock | output | 1 | Locked sequence in progress |
| mem_wide | output | 1 | Access is 128 bits |
| mem_addr | output | ADDR_W | Access address |
| mem_wdata | output | 2*HALF_W | Write data |
| mem_ready | input | 1 | Memory accepts or returns the beat |
| mem_rdata | input | 2*HALF_W | Read data, valid with ready on a read |
| done | output | 1 | One-cycle completion pulse |
| success | output | 1 | Compare matched |
| fault | output | 3 | 0 none, 1 not memory, 2 wide disabled, 3 wide misaligned, 4 alignment check |
| old_hi | output | HALF_W | Loaded value, high half |
| old_lo | output | HALF_W | Loaded value, low half |

## Verification
A state register that goes astray shows up at the memory port first. A missing or extra write leaves the lock high, or drops it without a write acknowledge, and this appears within one cycle of the read or write handshake. A wrong compare decision is different. It is only visible in the memory contents after the write and in `success`/`old_*` at the `done` pulse, so the bench compares every word of the touched location against a model copy. A fault decision that lets an access through appears as a read handshake before `done`. The bench counts read and write handshakes for each operation to catch this.

// File: rtl/cas_pkg.sv
package cas_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_CHECK      = 3'd1,
        ST_LOCK_READ  = 3'd2,
        ST_COMPARE    = 3'd3,
        ST_LOCK_WRITE = 3'd4,
        ST_DONE       = 3'd5
    } cas_state_e;

    // Lower code means higher priority.
    typedef enum logic [2:0] {
        FLT_NONE       = 3'd0,
        FLT_NOT_MEM    = 3'd1,
        FLT_NO_WIDE    = 3'd2,
        FLT_WIDE_ALIGN = 3'd3,
        FLT_ALIGN_CHK  = 3'd4
    } cas_fault_e;

endpackage

// File: rtl/cas_fault_check.sv
module cas_fault_check
    import cas_pkg::*;
#(
    parameter int HALF_W = 64
) (
    input  logic                     not_mem,
    input  logic                     wide,
    input  logic                     wide_en,
    input  logic                     ac_en,
    input  logic [1:0]               cpl,
    input  logic [$clog2(HALF_W/4)-1:0] addr_lo,
    output cas_fault_e               fault
);
    localparam int WIDE_LG   = $clog2(HALF_W / 4);
    localparam int NARROW_LG = $clog2(HALF_W / 8);

    logic wide_mis;
    logic narrow_mis;

    always_comb begin
        wide_mis   = (addr_lo != '0);
        narrow_mis = (addr_lo[NARROW_LG-1:0] != '0);
    end

    // R9: fixed priority chain.
    always_comb begin
        if (not_mem)
            fault = FLT_NOT_MEM;
        else if (wide && !wide_en)
            fault = FLT_NO_WIDE;
        else if (wide && wide_mis)
            fault = FLT_WIDE_ALIGN;
        else if (!wide && ac_en && (cpl == 2'd3) && narrow_mis)
            fault = FLT_ALIGN_CHK;
        else
            fault = FLT_NONE;
    end

    if (WIDE_LG <= NARROW_LG) begin : g_bad_width
        initial $error("cas_fault_check: HALF_W must be at least 16");
    end

endmodule

// File: rtl/cas_operand_path.sv
module cas_operand_path #(
    parameter int HALF_W = 64
) (
    input  logic                  wide,
    input  logic [HALF_W-1:0]     cmp_hi,
    input  logic [HALF_W-1:0]     cmp_lo,
    input  logic [HALF_W-1:0]     new_hi,
    input  logic [HALF_W-1:0]     new_lo,
    input  logic [2*HALF_W-1:0]   rdata,
    output logic                  match,
    output logic [2*HALF_W-1:0]   wdata,
    output logic [HALF_W-1:0]     old_hi,
    output logic [HALF_W-1:0]     old_lo
);
    localparam int DW    = 2 * HALF_W;
    localparam int NW    = HALF_W / 2;
    localparam int LANES = DW / 8;

    logic [DW-1:0]    exp_word;
    logic [DW-1:0]    got_word;
    logic [DW-1:0]    rep_word;
    logic [LANES-1:0] lane_eq;

    // R1: pack the register-pair halves according to width.
    always_comb begin
        if (wide) begin
            exp_word = {cmp_hi, cmp_lo};
            rep_word = {new_hi, new_lo};
            got_word = rdata;
        end else begin
            exp_word = {{HALF_W{1'b0}}, cmp_hi[NW-1:0], cmp_lo[NW-1:0]};
            rep_word = {{HALF_W{1'b0}}, new_hi[NW-1:0], new_lo[NW-1:0]};
            got_word = {{HALF_W{1'b0}}, rdata[HALF_W-1:0]};
        end
    end

    // Byte-lane comparators reduce into one match bit.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_eq[g] = (exp_word[g*8 +: 8] == got_word[g*8 +: 8]);
    end

    always_comb begin
        match = &lane_eq;
        // R2/R3: replacement on match, loaded value written back otherwise.
        wdata = match ? rep_word : got_word;
        if (wide) begin
            old_hi = got_word[DW-1:HALF_W];
            old_lo = got_word[HALF_W-1:0];
        end else begin
            old_hi = {{NW{1'b0}}, got_word[HALF_W-1:NW]};
            old_lo = {{NW{1'b0}}, got_word[NW-1:0]};
        end
    end

endmodule

// File: rtl/cas_fsm.sv
module cas_fsm
    import cas_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       fault_hit,
    input  logic       mem_ready,
    output cas_state_e state,
    output logic       req_ready,
    output logic       mem_valid,
    output logic       mem_write,
    output logic       mem_lock,
    output logic       done,
    output logic       chk_stb,
    output logic       rd_ack,
    output logic       cmp_stb
);
    cas_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:       if (req_valid) nxt = ST_CHECK;
            ST_CHECK:      nxt = fault_hit ? ST_DONE : ST_LOCK_READ;
            ST_LOCK_READ:  if (mem_ready) nxt = ST_COMPARE;
            ST_COMPARE:    nxt = ST_LOCK_WRITE;
            ST_LOCK_WRITE: if (mem_ready) nxt = ST_DONE;
            ST_DONE:       nxt = ST_IDLE;
            default:       nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    always_comb begin
        req_ready = 1'b0;
        mem_valid = 1'b0;
        mem_write = 1'b0;
        mem_lock  = 1'b0;
        done      = 1'b0;
        chk_stb   = 1'b0;
        rd_ack    = 1'b0;
        cmp_stb   = 1'b0;
        unique case (state)
            ST_IDLE:       req_ready = 1'b1;
            ST_CHECK:      chk_stb   = 1'b1;
            ST_LOCK_READ: begin
                mem_valid = 1'b1;
                mem_lock  = 1'b1;
                rd_ack    = mem_ready;
            end
            ST_COMPARE: begin
                mem_lock = 1'b1;
                cmp_stb  = 1'b1;
            end
            ST_LOCK_WRITE: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_lock  = 1'b1;
            end
            ST_DONE:       done = 1'b1;
            default:       req_ready = 1'b0;
        endcase
    end

endmodule

// File: rtl/cas_unit.sv
module cas_unit
    import cas_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int HALF_W = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                req_wide,
    input  logic                req_not_mem,
    input  logic [HALF_W-1:0]   req_cmp_hi,
    input  logic [HALF_W-1:0]   req_cmp_lo,
    input  logic [HALF_W-1:0]   req_new_hi,
    input  logic [HALF_W-1:0]   req_new_lo,
    input  logic                wide_enable,
    input  logic                align_chk_en,
    input  logic [1:0]          priv_level,
    input  logic [4:0]          flags_in,
    output logic [4:0]          flags_out,
    output logic                eq_flag,
    output logic                mem_req_valid,
    output logic                mem_req_write,
    output logic                mem_lock,
    output logic                mem_wide,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [2*HALF_W-1:0] mem_wdata,
    input  logic                mem_ready,
    input  logic [2*HALF_W-1:0] mem_rdata,
    output logic                done,
    output logic                success,
    output logic [2:0]          fault,
    output logic [HALF_W-1:0]   old_hi,
    output logic [HALF_W-1:0]   old_lo
);
    localparam int DW      = 2 * HALF_W;
    localparam int WIDE_LG = $clog2(HALF_W / 4);

    cas_state_e  state;
    cas_fault_e  fault_now;
    cas_fault_e  fault_q;
    logic        chk_stb, rd_ack, cmp_stb, accept;

    logic [ADDR_W-1:0] addr_q;
    logic              wide_q, not_mem_q, wide_en_q, ac_en_q;
    logic [1:0]        cpl_q;
    logic [HALF_W-1:0] cmp_hi_q, cmp_lo_q, new_hi_q, new_lo_q;
    logic [DW-1:0]     rdata_q, wdata_q;
    logic              success_q, eq_q;
    logic [HALF_W-1:0] old_hi_q, old_lo_q;

    logic              p_match;
    logic [DW-1:0]     p_wdata;
    logic [HALF_W-1:0] p_old_hi, p_old_lo;

    cas_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .fault_hit (fault_now != FLT_NONE),
        .mem_ready (mem_ready),
        .state     (state),
        .req_ready (req_ready),
        .mem_valid (mem_req_valid),
        .mem_write (mem_req_write),
        .mem_lock  (mem_lock),
        .done      (done),
        .chk_stb   (chk_stb),
        .rd_ack    (rd_ack),
        .cmp_stb   (cmp_stb)
    );

    cas_fault_check #(.HALF_W(HALF_W)) u_fault (
        .not_mem (not_mem_q),
        .wide    (wide_q),
        .wide_en (wide_en_q),
        .ac_en   (ac_en_q),
        .cpl     (cpl_q),
        .addr_lo (addr_q[WIDE_LG-1:0]),
        .fault   (fault_now)
    );

    cas_operand_path #(.HALF_W(HALF_W)) u_path (
        .wide   (wide_q),
        .cmp_hi (cmp_hi_q),
        .cmp_lo (cmp_lo_q),
        .new_hi (new_hi_q),
        .new_lo (new_lo_q),
        .rdata  (rdata_q),
        .match  (p_match),
        .wdata  (p_wdata),
        .old_hi (p_old_hi),
        .old_lo (p_old_lo)
    );

    assign accept = req_valid && req_ready;

    // Request capture: operands are frozen for the whole locked sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q    <= '0;
            wide_q    <= 1'b0;
            not_mem_q <= 1'b0;
            wide_en_q <= 1'b0;
            ac_en_q   <= 1'b0;
            cpl_q     <= 2'd0;
            cmp_hi_q  <= '0;
            cmp_lo_q  <= '0;
            new_hi_q  <= '0;
            new_lo_q  <= '0;
        end else if (accept) begin
            addr_q    <= req_addr;
            wide_q    <= req_wide;
            not_mem_q <= req_not_mem;
            wide_en_q <= wide_enable;
            ac_en_q   <= align_chk_en;
            cpl_q     <= priv_level;
            cmp_hi_q  <= req_cmp_hi;
            cmp_lo_q  <= req_cmp_lo;
            new_hi_q  <= req_new_hi;
            new_lo_q  <= req_new_lo;
        end
    end

    // Data path registers and results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q   <= '0;
            wdata_q   <= '0;
            fault_q   <= FLT_NONE;
            success_q <= 1'b0;
            eq_q      <= 1'b0;
            old_hi_q  <= '0;
            old_lo_q  <= '0;
        end else begin
            if (chk_stb) begin
                fault_q   <= fault_now;
                success_q <= 1'b0;
            end
            if (rd_ack)
                rdata_q <= mem_rdata;
            if (cmp_stb) begin
                wdata_q   <= p_wdata;
                success_q <= p_match;
                eq_q      <= p_match;
                old_hi_q  <= p_old_hi;
                old_lo_q  <= p_old_lo;
            end
        end
    end

    assign mem_addr  = addr_q;
    assign mem_wide  = wide_q;
    assign mem_wdata = wdata_q;
    assign success   = success_q;
    assign fault     = fault_q;
    assign old_hi    = old_hi_q;
    assign old_lo    = old_lo_q;
    assign eq_flag   = eq_q;
    assign flags_out = flags_in;

endmodule

// File: rtl/cas_unit_chk.sv
module cas_unit_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              mem_req_valid,
    input logic              mem_req_write,
    input logic              mem_lock,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              done,
    input logic              success,
    input logic [2:0]        fault
);
    logic              touched;
    logic [ADDR_W-1:0] rd_addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            touched   <= 1'b0;
            rd_addr_q <= '0;
        end else begin
            if (req_valid && req_ready)
                touched <= 1'b0;
            else if (mem_req_valid)
                touched <= 1'b1;
            if (mem_req_valid && !mem_req_write && mem_ready)
                rd_addr_q <= mem_addr;
        end
    end

    assert_read_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_lock);

    assert_lock_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_write && mem_ready) |=> mem_lock);

    assert_unlock_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_lock) |-> $past(mem_req_valid && mem_req_write && mem_ready));

    assert_write_same_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |-> (mem_addr == rd_addr_q));

    assert_fault_no_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault != 3'd0) |-> !touched);

    assert_misalign_no_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault == 3'd3) |-> !touched);

    assert_success_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && success) |-> (fault == 3'd0));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_ready) |=>
            (mem_req_valid && $stable(mem_addr) && $stable(mem_req_write)));

endmodule

bind cas_unit cas_unit_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_write (mem_req_write),
    .mem_lock      (mem_lock),
    .mem_ready     (mem_ready),
    .mem_addr      (mem_addr),
    .done          (done),
    .success       (success),
    .fault         (fault)
);

// File: tb/cas_unit_tb.sv
module cas_unit_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [31:0]  req_addr = '0;
    logic         req_wide = 1'b0;
    logic         req_not_mem = 1'b0;
    logic [63:0]  req_cmp_hi = '0, req_cmp_lo = '0, req_new_hi = '0, req_new_lo = '0;
    logic         wide_enable = 1'b1;
    logic         align_chk_en = 1'b0;
    logic [1:0]   priv_level = 2'd0;
    logic [4:0]   flags_in = '0;
    logic [4:0]   flags_out;
    logic         eq_flag;
    logic         mem_req_valid, mem_req_write, mem_lock, mem_wide;
    logic [31:0]  mem_addr;
    logic [127:0] mem_wdata;
    logic         mem_ready = 1'b0;
    logic [127:0] mem_rdata;
    logic         done, success;
    logic [2:0]   fault;
    logic [63:0]  old_hi, old_lo;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    cas_unit dut_i (.*);

    // Memory model: 32 words of 64 bits, word index from address bits [7:3].
    logic [63:0] mem [0:31];
    logic        init_we = 1'b0;
    logic [4:0]  init_idx = '0;
    logic [63:0] init_data = '0;
    int          rd_hs = 0, wr_hs = 0;
    logic [4:0]  midx;

    assign midx = mem_addr[7:3];
    assign mem_rdata = mem_wide ? {mem[{midx[4:1], 1'b1}], mem[{midx[4:1], 1'b0}]}
                                : {64'd0, mem[midx]};

    always @(posedge clk) begin
        if (init_we)
            mem[init_idx] <= init_data;
        else if (mem_req_valid && mem_ready) begin
            if (mem_req_write) begin
                wr_hs <= wr_hs + 1;
                if (mem_wide) begin
                    mem[{midx[4:1], 1'b0}] <= mem_wdata[63:0];
                    mem[{midx[4:1], 1'b1}] <= mem_wdata[127:64];
                end else
                    mem[midx] <= mem_wdata[63:0];
            end else
                rd_hs <= rd_hs + 1;
        end
    end

    always @(negedge clk) mem_ready = ($urandom % 3) != 0;

    task automatic check(input logic ok, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_fault(input logic nm, input logic w, input logic we,
                                             input logic ac, input logic [1:0] cpl,
                                             input logic [31:0] a);
        if (nm) return 3'd1;
        if (w && !we) return 3'd2;
        if (w && a[3:0] != 4'd0) return 3'd3;
        if (!w && ac && cpl == 2'd3 && a[2:0] != 3'd0) return 3'd4;
        return 3'd0;
    endfunction

    task automatic run_op(input logic w, input logic nm, input logic we, input logic ac,
                          input logic [1:0] cpl, input logic [31:0] a,
                          input logic [63:0] ch, input logic [63:0] cl,
                          input logic [63:0] nh, input logic [63:0] nl);
        logic [2:0]   ef;
        logic [127:0] got, expw, rep, nw;
        logic [63:0]  eoh, eol;
        logic         es, eq_before;
        logic [4:0]   i0, i1;
        logic [4:0]   fl;
        int           rd0, wr0, n;
        ef = exp_fault(nm, w, we, ac, cpl, a);
        i0 = w ? {a[7:4], 1'b0} : a[7:3];
        i1 = {a[7:4], 1'b1};
        got  = w ? {mem[i1], mem[i0]} : {64'd0, mem[i0]};
        expw = w ? {ch, cl} : {64'd0, ch[31:0], cl[31:0]};
        rep  = w ? {nh, nl} : {64'd0, nh[31:0], nl[31:0]};
        es   = (got == expw);
        nw   = es ? rep : got;
        eoh  = w ? got[127:64] : {32'd0, got[63:32]};
        eol  = w ? got[63:0]   : {32'd0, got[31:0]};
        eq_before = eq_flag;
        rd0 = rd_hs; wr0 = wr_hs;
        fl = 5'($urandom);
        @(negedge clk);
        req_valid = 1'b1; req_wide = w; req_not_mem = nm; wide_enable = we;
        align_chk_en = ac; priv_level = cpl; req_addr = a;
        req_cmp_hi = ch; req_cmp_lo = cl; req_new_hi = nh; req_new_lo = nl;
        flags_in = fl;
        @(negedge clk);
        req_valid = 1'b0;
        req_cmp_hi = ~ch; req_new_lo = ~nl;
        check(flags_out == fl, "R10 flags pass through", flags_out, fl);
        n = 0;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
        end
        check(done == 1'b1, "R11 done arrives", done, 1);
        check(fault == ef, "R9 fault code (R5 R6 R7 R8)", fault, ef);
        if (ef == 3'd0) begin
            check(success == es, es ? "R2 success flag" : "R3 success cleared", success, es);
            check(old_hi == eoh, "R3 old_hi (R1 halves)", old_hi, eoh);
            check(old_lo == eol, "R3 old_lo (R1 halves)", old_lo, eol);
            check(eq_flag == es, "R10 eq_flag follows compare", eq_flag, es);
            check(rd_hs - rd0 == 1 && wr_hs - wr0 == 1, "R4 one locked read and write",
                  128'((rd_hs - rd0) * 16 + (wr_hs - wr0)), 128'h11);
            check(mem[i0] == nw[63:0], "R2 R3 memory low word", mem[i0], nw[63:0]);
            if (w)
                check(mem[i1] == nw[127:64], "R2 R3 memory high word", mem[i1], nw[127:64]);
        end else begin
            check(rd_hs == rd0 && wr_hs == wr0, "R8 no access on fault",
                  128'((rd_hs - rd0) * 16 + (wr_hs - wr0)), 128'h0);
            check(eq_flag == eq_before, "R10 eq_flag kept on fault", eq_flag, eq_before);
        end
        @(negedge clk);
        check(done == 1'b0, "R11 done single cycle", done, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [63:0] v;
        void'($urandom(32'd20240611));
        for (int k = 0; k < 32; k++) begin
            @(negedge clk);
            init_we = 1'b1; init_idx = 5'(k);
            init_data = {$urandom, $urandom};
        end
        @(negedge clk);
        init_we = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1, "R12 reset req_ready", req_ready, 1);
        check(!done && !mem_req_valid && !mem_lock, "R12 reset idle port",
              {done, mem_req_valid, mem_lock}, 0);
        check(!eq_flag && !success && fault == 3'd0, "R12 reset results",
              {eq_flag, success, fault}, 0);
        rst_n = 1'b1;

        // Directed: 128-bit match, then mismatch.
        run_op(1, 0, 1, 0, 0, 32'h20, mem[5], mem[4], 64'hA5A5, 64'h5A5A);
        run_op(1, 0, 1, 0, 0, 32'h20, 64'h1, 64'h2, 64'h3, 64'h4);
        // R1: 64-bit match with garbage in upper input bits.
        v = mem[9];
        run_op(0, 0, 1, 0, 0, 32'h48, {32'hDEAD_BEEF, v[63:32]}, {32'hCAFE_F00D, v[31:0]},
               64'hFFFF_FFFF_1234_5678, 64'hEEEE_EEEE_9ABC_DEF0);
        // Fault priority corners.
        run_op(1, 1, 0, 1, 3, 32'h23, 0, 0, 0, 0);      // R8 wins all
        run_op(1, 0, 0, 1, 3, 32'h23, 0, 0, 0, 0);      // R6 over R5
        run_op(1, 0, 1, 1, 3, 32'h28, 0, 0, 0, 0);      // R5
        run_op(0, 0, 1, 1, 3, 32'h44, 0, 0, 0, 0);      // R7
        run_op(0, 0, 1, 1, 0, 32'h44, 0, 0, 0, 0);      // R7 absent: privilege
        run_op(0, 0, 1, 0, 3, 32'h44, 0, 0, 0, 0);      // R7 absent: enable
        run_op(1, 0, 0, 0, 0, 32'h30, mem[7], mem[6], 1, 2); // R6 aligned but disabled

        // Constrained random mix.
        for (int k = 0; k < 120; k++) begin
            logic        w, nm, we, ac, hit;
            logic [1:0]  cpl;
            logic [31:0] a;
            logic [4:0]  i;
            logic [63:0] ch, cl;
            w   = 1'($urandom);
            nm  = ($urandom % 16) == 0;
            we  = ($urandom % 8) != 0;
            ac  = 1'($urandom);
            cpl = 2'($urandom);
            i   = 5'($urandom);
            a   = {24'd0, i, 3'd0};
            if (w) a[3] = 1'b0;
            if (($urandom % 6) == 0) a[2:0] = 3'($urandom);
            if (w && ($urandom % 8) == 0) a[3] = 1'b1;
            hit = 1'($urandom);
            if (w) begin
                ch = hit ? mem[{a[7:4], 1'b1}] : {$urandom, $urandom};
                cl = hit ? mem[{a[7:4], 1'b0}] : {$urandom, $urandom};
            end else begin
                v  = mem[a[7:3]];
                ch = {$urandom, hit ? v[63:32] : $urandom};
                cl = {$urandom, hit ? v[31:0]  : $urandom};
            end
            run_op(w, nm, we, ac, cpl, a, ch, cl, {$urandom, $urandom}, {$urandom, $urandom});
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule